// File: doc/BRIEF.md
# Serial Flash Program and Erase Sequencer

This block sits on the host side of a serial flash and carries out the operations that modify the device: page program, sector erase, bulk erase and status-register write. A request gives the operation kind, a 24-bit address, a byte count for programs and a value for status writes. The block emits every SPI frame that the operation needs and keeps a busy flag raised until the flash reports that it is idle again.

Each modifying frame is preceded by a write-enable frame of its own. A program is cut into pieces so that no piece crosses a page boundary, and each piece gets its own write-enable, program frame and completion wait. To detect completion, the block reads the status register at a programmable interval until the write-in-progress bit is clear. It gives up with an error flag after a programmable number of busy readings. Program data is pulled one byte at a time through a take strobe. The serial side runs in SPI mode 0 with a parameterised clock divider.

Top module: `flash_pe_seq`

## Requirements
- R1: Every program, sector-erase, bulk-erase or status-write frame is immediately preceded by a frame holding only the write-enable byte 06h.
- R2: A program frame is 02h, then the three address bytes with the most significant first, then the data bytes in stream order. `wdata_take_o` pulses once for each data byte, one cycle after the byte on `wdata_i` was captured.
- R3: A program frame never crosses a PAGE_BYTES boundary (default 256). A program of N bytes at address A is issued as one write-enable/program/poll group per page it touches, and every group after the first starts at a page boundary.
- R4: A sector erase (`req_op_i`=1) sends D8h and three address bytes. A bulk erase (`req_op_i`=2) sends C7h alone. A status write (`req_op_i`=3) sends 01h followed by `req_sr_i`. A program has `req_op_i`=0.
- R5: After each command frame, two-byte frames 05h,00h are sent until the final bit of the second received byte (status bit 0) is 0. The other status bits have no effect.
- R6: Chip select stays high for at least `poll_gap_i` plus 2*SCK_HALF clock cycles before every status-read frame.
- R7: When `poll_max_i` status reads (at least one) in a row show the device busy, the operation ends, remaining pages are dropped, and `timeout_err_o` rises one cycle before `done_o`. The flag stays high until the next request is accepted, and it clears in that cycle.
- R8: A request is accepted only while `busy_o` is low, and `busy_o` is high from the next cycle until completion. `done_o` pulses for one cycle in the cycle `busy_o` falls. Requests made while busy have no effect.
- R9: SPI mode 0: `spi_sclk_o` is low whenever chip select is high or changes, and bytes go out MSB first. Chip select stays high for at least 2*SCK_HALF cycles between frames.
- R10: A program with zero length sends no frames, and `done_o` pulses two cycles after the accepting edge.
- R11: During and after reset: chip select high, clock low, `busy_o`, `done_o`, `timeout_err_o` and `wdata_take_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken while idle |
| req_op_i | input | 2 | 0 program, 1 sector erase, 2 bulk erase, 3 status write |
| req_addr_i | input | 24 | Start address |
| req_len_i | input | LEN_W | Program byte count |
| req_sr_i | input | 8 | Value for a status write |
| wdata_i | input | 8 | Current program data byte |
| wdata_take_o | output | 1 | Current data byte consumed, present the next |
| poll_gap_i | input | TMR_W | Idle cycles added before each status read |
| poll_max_i | input | TMR_W | Busy status reads tolerated before timeout |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_err_o | output | 1 | Last operation timed out |
| spi_sclk_o | output | 1 | SPI clock |
| spi_cs_no | output | 1 | SPI chip select, active low |
| spi_mosi_o | output | 1 | SPI data to flash |
| spi_miso_i | input | 1 | SPI data from flash |

## Verification
`busy_o` is due one cycle after the accepting edge. `done_o` for a zero-length program follows one cycle later, so the bench samples both on the falling edges that follow, at those exact cycle counts. For real operations the finish time depends on the serial traffic. The bench therefore samples on every falling edge until `done_o`, requiring `busy_o` throughout, and then compares the complete captured frame list with one built arithmetically from the address, length, page size and the model's busy count. The flash model records the chip-select-high cycles before each frame, and these are checked against lower bounds rather than exact values. The take strobe is counted on falling edges, one cycle after each capture.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BULK = 2'd2,
        OP_WRSR = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        FK_WREN = 2'd0,
        FK_CMD  = 2'd1,
        FK_POLL = 2'd2
    } frame_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FRAME = 3'd1,
        ST_GAP   = 3'd2,
        ST_WAIT  = 3'd3,
        ST_FIN   = 3'd4
    } st_e;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_PROG = 8'h02;
    localparam logic [7:0] OPC_SECT = 8'hD8;
    localparam logic [7:0] OPC_BULK = 8'hC7;
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_WRSR = 8'h01;

    function automatic logic [7:0] op_code(input op_e op);
        case (op)
            OP_PROG: return OPC_PROG;
            OP_SECT: return OPC_SECT;
            OP_BULK: return OPC_BULK;
            default: return OPC_WRSR;
        endcase
    endfunction

endpackage

// File: rtl/fseq_spi_shifter.sv
module fseq_spi_shifter #(
    parameter int SCK_HALF = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       done_o,
    output logic       rx_last_o
);
    localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    typedef struct packed {
        logic             active;
        logic             sclk;
        logic [2:0]       bitn;
        logic [DIV_W-1:0] div;
        logic [7:0]       sh;
        logic             rx;
        logic             done;
    } sh_t;

    sh_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.active) begin
            if (start_i) begin
                r_d.active = 1'b1;
                r_d.sh     = tx_i;
                r_d.bitn   = '0;
                r_d.div    = '0;
                r_d.sclk   = 1'b0;
            end
        end else if (r_q.div == DIV_W'(SCK_HALF - 1)) begin
            r_d.div = '0;
            if (!r_q.sclk) begin
                r_d.sclk = 1'b1;
                r_d.rx   = miso_i;
            end else begin
                r_d.sclk = 1'b0;
                if (r_q.bitn == 3'd7) begin
                    r_d.active = 1'b0;
                    r_d.done   = 1'b1;
                end else begin
                    r_d.bitn = r_q.bitn + 3'd1;
                    r_d.sh   = {r_q.sh[6:0], 1'b0};
                end
            end
        end else begin
            r_d.div = r_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign sclk_o    = r_q.sclk;
    assign mosi_o    = r_q.sh[7];
    assign done_o    = r_q.done;
    assign rx_last_o = r_q.rx;

endmodule

// File: rtl/fseq_chunk.sv
module fseq_chunk #(
    parameter int PAGE_W = 8,
    parameter int LEN_W  = 16,
    parameter int CHK_W  = PAGE_W + 1
) (
    input  logic [PAGE_W-1:0] offs_i,
    input  logic [LEN_W-1:0]  remain_i,
    output logic [CHK_W-1:0]  chunk_o
);
    localparam int CMP_W = (LEN_W > CHK_W) ? LEN_W : CHK_W;

    logic [CHK_W-1:0] room;
    logic [CMP_W-1:0] rem_x, room_x;

    always_comb begin
        room    = {1'b1, {PAGE_W{1'b0}}} - {1'b0, offs_i};
        rem_x   = CMP_W'(remain_i);
        room_x  = CMP_W'(room);
        chunk_o = (rem_x < room_x) ? CHK_W'(rem_x) : room;
    end

endmodule

// File: rtl/fseq_byte_mux.sv
module fseq_byte_mux
    import flash_seq_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int CHK_W = 9
) (
    input  frame_e           kind_i,
    input  op_e              op_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [23:0]      addr_i,
    input  logic [7:0]       sr_i,
    input  logic [7:0]       wdata_i,
    input  logic [CHK_W-1:0] chunk_i,
    output logic [7:0]       byte_o,
    output logic             is_data_o,
    output logic             last_o
);
    logic [IDX_W-1:0] flen;

    always_comb begin
        byte_o    = 8'h00;
        is_data_o = 1'b0;
        flen      = IDX_W'(1);
        case (kind_i)
            FK_WREN: begin
                byte_o = OPC_WREN;
            end
            FK_POLL: begin
                flen   = IDX_W'(2);
                byte_o = (idx_i == '0) ? OPC_RDSR : 8'h00;
            end
            default: begin
                case (op_i)
                    OP_PROG: flen = IDX_W'(chunk_i) + IDX_W'(4);
                    OP_SECT: flen = IDX_W'(4);
                    OP_BULK: flen = IDX_W'(1);
                    default: flen = IDX_W'(2);
                endcase
                if (idx_i == '0) begin
                    byte_o = op_code(op_i);
                end else if (op_i == OP_WRSR) begin
                    byte_o = sr_i;
                end else if (idx_i == IDX_W'(1)) begin
                    byte_o = addr_i[23:16];
                end else if (idx_i == IDX_W'(2)) begin
                    byte_o = addr_i[15:8];
                end else if (idx_i == IDX_W'(3)) begin
                    byte_o = addr_i[7:0];
                end else begin
                    byte_o    = wdata_i;
                    is_data_o = (op_i == OP_PROG);
                end
            end
        endcase
        last_o = (idx_i == flen - IDX_W'(1));
    end

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
    import flash_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int LEN_W      = 16,
    parameter int SCK_HALF   = 2,
    parameter int TMR_W      = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_valid_i,
    input  logic [1:0]       req_op_i,
    input  logic [23:0]      req_addr_i,
    input  logic [LEN_W-1:0] req_len_i,
    input  logic [7:0]       req_sr_i,
    input  logic [7:0]       wdata_i,
    output logic             wdata_take_o,
    input  logic [TMR_W-1:0] poll_gap_i,
    input  logic [TMR_W-1:0] poll_max_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             timeout_err_o,
    output logic             spi_sclk_o,
    output logic             spi_cs_no,
    output logic             spi_mosi_o,
    input  logic             spi_miso_i
);
    localparam int PAGE_W  = $clog2(PAGE_BYTES);
    localparam int CHK_W   = PAGE_W + 1;
    localparam int IDX_W   = PAGE_W + 2;
    localparam int GAP_CYC = 2 * SCK_HALF;

    typedef struct packed {
        st_e              st;
        frame_e           kind;
        op_e              op;
        logic [23:0]      addr;
        logic [LEN_W-1:0] remain;
        logic [CHK_W-1:0] chunk;
        logic [7:0]       sr;
        logic [IDX_W-1:0] idx;
        logic             inflight;
        logic [TMR_W-1:0] timer;
        logic [TMR_W-1:0] polls;
        logic             wip;
        logic             busy;
        logic             done;
        logic             err;
        logic             cs_n;
        logic             start;
        logic             take;
    } seq_t;

    seq_t r_q, r_d;

    logic             sh_done, sh_rx;
    logic [7:0]       tx_byte;
    logic             tx_is_data, tx_last;
    logic [CHK_W-1:0] chunk_w;

    fseq_spi_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (r_q.start),
        .tx_i      (tx_byte),
        .miso_i    (spi_miso_i),
        .sclk_o    (spi_sclk_o),
        .mosi_o    (spi_mosi_o),
        .done_o    (sh_done),
        .rx_last_o (sh_rx)
    );

    fseq_chunk #(.PAGE_W(PAGE_W), .LEN_W(LEN_W), .CHK_W(CHK_W)) u_chunk (
        .offs_i   (r_q.addr[PAGE_W-1:0]),
        .remain_i (r_q.remain),
        .chunk_o  (chunk_w)
    );

    fseq_byte_mux #(.IDX_W(IDX_W), .CHK_W(CHK_W)) u_mux (
        .kind_i    (r_q.kind),
        .op_i      (r_q.op),
        .idx_i     (r_q.idx),
        .addr_i    (r_q.addr),
        .sr_i      (r_q.sr),
        .wdata_i   (wdata_i),
        .chunk_i   (r_q.chunk),
        .byte_o    (tx_byte),
        .is_data_o (tx_is_data),
        .last_o    (tx_last)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.start = 1'b0;
        r_d.take  = r_q.start && tx_is_data;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    r_d.busy   = 1'b1;
                    r_d.err    = 1'b0;
                    r_d.op     = op_e'(req_op_i);
                    r_d.addr   = req_addr_i;
                    r_d.remain = req_len_i;
                    r_d.sr     = req_sr_i;
                    if (op_e'(req_op_i) == OP_PROG && req_len_i == '0) begin
                        r_d.st = ST_FIN;
                    end else begin
                        r_d.st       = ST_FRAME;
                        r_d.kind     = FK_WREN;
                        r_d.idx      = '0;
                        r_d.inflight = 1'b0;
                        r_d.cs_n     = 1'b0;
                    end
                end
            end
            ST_FRAME: begin
                if (!r_q.inflight) begin
                    r_d.start    = 1'b1;
                    r_d.inflight = 1'b1;
                end else if (sh_done) begin
                    r_d.inflight = 1'b0;
                    if (tx_last) begin
                        r_d.cs_n  = 1'b1;
                        r_d.st    = ST_GAP;
                        r_d.timer = TMR_W'(GAP_CYC - 1);
                        if (r_q.kind == FK_POLL) begin
                            r_d.wip = sh_rx;
                        end
                        if (r_q.kind == FK_CMD) begin
                            r_d.polls = '0;
                            if (r_q.op == OP_PROG) begin
                                r_d.addr   = r_q.addr + 24'(r_q.chunk);
                                r_d.remain = r_q.remain - LEN_W'(r_q.chunk);
                            end
                        end
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (r_q.timer != '0) begin
                    r_d.timer = r_q.timer - 1'b1;
                end else begin
                    case (r_q.kind)
                        FK_WREN: begin
                            r_d.st    = ST_FRAME;
                            r_d.kind  = FK_CMD;
                            r_d.idx   = '0;
                            r_d.cs_n  = 1'b0;
                            r_d.chunk = chunk_w;
                        end
                        FK_CMD: begin
                            r_d.st    = ST_WAIT;
                            r_d.timer = poll_gap_i;
                        end
                        default: begin
                            if (!r_q.wip) begin
                                if (r_q.op == OP_PROG && r_q.remain != '0) begin
                                    r_d.st   = ST_FRAME;
                                    r_d.kind = FK_WREN;
                                    r_d.idx  = '0;
                                    r_d.cs_n = 1'b0;
                                end else begin
                                    r_d.st = ST_FIN;
                                end
                            end else if (({1'b0, r_q.polls} + 1'b1) >= {1'b0, poll_max_i}) begin
                                r_d.err = 1'b1;
                                r_d.st  = ST_FIN;
                            end else begin
                                r_d.polls = r_q.polls + 1'b1;
                                r_d.st    = ST_WAIT;
                                r_d.timer = poll_gap_i;
                            end
                        end
                    endcase
                end
            end
            ST_WAIT: begin
                if (r_q.timer != '0) begin
                    r_d.timer = r_q.timer - 1'b1;
                end else begin
                    r_d.st   = ST_FRAME;
                    r_d.kind = FK_POLL;
                    r_d.idx  = '0;
                    r_d.cs_n = 1'b0;
                end
            end
            ST_FIN: begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q      <= '0;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign wdata_take_o  = r_q.take;
    assign busy_o        = r_q.busy;
    assign done_o        = r_q.done;
    assign timeout_err_o = r_q.err;
    assign spi_cs_no     = r_q.cs_n;

endmodule

// File: rtl/flash_pe_seq_chk.sv
module flash_pe_seq_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic req_valid_i,
    input logic wdata_take_o,
    input logic busy_o,
    input logic done_o,
    input logic timeout_err_o,
    input logic spi_sclk_o,
    input logic spi_cs_no
);
    assert_done_ends_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $fell(busy_o));

    assert_accept_needs_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(req_valid_i));

    assert_idle_cs_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> spi_cs_no);

    assert_sclk_idle_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        spi_cs_no |-> !spi_sclk_o);

    assert_cs_edge_sclk_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(spi_cs_no) |-> (!spi_sclk_o && !$past(spi_sclk_o)));

    assert_take_in_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdata_take_o |-> (busy_o && !spi_cs_no));

    assert_err_before_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(timeout_err_o) |=> done_o);

    assert_err_clears_on_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(timeout_err_o) |-> $rose(busy_o));

endmodule

bind flash_pe_seq flash_pe_seq_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .wdata_take_o  (wdata_take_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .timeout_err_o (timeout_err_o),
    .spi_sclk_o    (spi_sclk_o),
    .spi_cs_no     (spi_cs_no)
);

// File: tb/flash_pe_seq_bench.sv
module flash_pe_seq_bench;
    localparam int PG   = 16;
    localparam int LW   = 16;
    localparam int HALF = 2;
    localparam int TW   = 16;
    localparam int GAP  = 2 * HALF;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          req_valid;
    logic [1:0]    req_op;
    logic [23:0]   req_addr;
    logic [LW-1:0] req_len;
    logic [7:0]    req_sr;
    logic [7:0]    wdata;
    logic          wdata_take;
    logic [TW-1:0] poll_gap, poll_max;
    logic          busy, done, err;
    logic          spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    flash_pe_seq #(.PAGE_BYTES(PG), .LEN_W(LW), .SCK_HALF(HALF), .TMR_W(TW)) u_flash_pe_seq (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
        .req_addr_i(req_addr), .req_len_i(req_len), .req_sr_i(req_sr),
        .wdata_i(wdata), .wdata_take_o(wdata_take), .poll_gap_i(poll_gap),
        .poll_max_i(poll_max), .busy_o(busy), .done_o(done), .timeout_err_o(err),
        .spi_sclk_o(spi_sclk), .spi_cs_no(spi_cs_n), .spi_mosi_o(spi_mosi),
        .spi_miso_i(spi_miso)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // flash model
    logic [7:0]  mb [0:4095];
    int          mfs [0:255];
    int          mfl [0:255];
    int          mgap [0:255];
    int          mfc = 0, mnb = 0, hi_cnt = 0, polls_left = 0, busy_cfg = 0, seq_viol = 0;
    logic [15:0] bitc = '0;
    logic [7:0]  shreg = '0;
    bit          wel = 0, model_on = 0;
    logic [7:0]  stat_b;

    assign stat_b   = (polls_left > 0) ? 8'h01 : 8'hFE;
    assign spi_miso = stat_b[3'd7 - bitc[2:0]];

    always @(negedge clk) hi_cnt <= spi_cs_n ? hi_cnt + 1 : 0;

    always @(negedge spi_cs_n) if (model_on) begin
        chk(spi_sclk == 1'b0, "R9", "sclk at cs fall", int'(spi_sclk), 0);
        if (mfc < 256) begin
            mfs[mfc]  = mnb;
            mgap[mfc] = hi_cnt;
        end
        bitc = '0;
    end

    always @(posedge spi_sclk) if (model_on && !spi_cs_n) begin
        shreg = {shreg[6:0], spi_mosi};
        bitc  = bitc + 16'd1;
        if (bitc[2:0] == 3'd0 && mnb < 4096) begin
            mb[mnb] = shreg;
            mnb++;
        end
    end

    always @(posedge spi_cs_n) if (model_on) begin
        chk(spi_sclk == 1'b0, "R9", "sclk at cs rise", int'(spi_sclk), 0);
        if (mfc < 256) begin
            logic [7:0] first;
            mfl[mfc] = mnb - mfs[mfc];
            first = (mfl[mfc] > 0) ? mb[mfs[mfc]] : 8'h00;
            case (first)
                8'h06: wel = 1;
                8'h02, 8'hD8, 8'hC7, 8'h01: begin
                    if (!wel) seq_viol++;
                    wel = 0;
                    polls_left = busy_cfg;
                end
                8'h05: if (polls_left > 0) polls_left--;
                default: ;
            endcase
            mfc++;
        end
    end

    // data stream
    int         taken = 0;
    logic [7:0] seed  = 8'h00;
    function automatic logic [7:0] pat(input int k, input logic [7:0] s);
        return 8'(k * 37) ^ s;
    endfunction
    assign wdata = pat(taken, seed);
    always @(negedge clk) if (wdata_take) taken <= taken + 1;

    // expected frames
    logic [7:0] eb [0:4095];
    int         efs [0:255];
    int         efl [0:255];
    int         efc = 0, enb = 0;

    task automatic ex_open();
        efs[efc] = enb;
    endtask
    task automatic ex_b(input logic [7:0] b);
        eb[enb] = b;
        enb++;
    endtask
    task automatic ex_close();
        efl[efc] = enb - efs[efc];
        efc++;
    endtask
    task automatic ex_polls(input int busy_n, input int pmax, output bit to);
        int lim, n;
        lim = (pmax < 1) ? 1 : pmax;
        to  = (busy_n >= lim);
        n   = to ? lim : busy_n + 1;
        for (int i = 0; i < n; i++) begin
            ex_open(); ex_b(8'h05); ex_b(8'h00); ex_close();
        end
    endtask
    task automatic ex_addr(input int a);
        ex_b(8'(a >> 16)); ex_b(8'(a >> 8)); ex_b(8'(a));
    endtask

    task automatic run_op(input int op, input int addr, input int len, input int sr,
                          input int busy_n, input int pmax, input int pgap, input bit poke);
        int a, rem, c, k, cyc, pages, min_gap, min_pgap;
        bit to, bz_ok, frames_ok;
        string rq;
        mfc = 0; mnb = 0; efc = 0; enb = 0; seq_viol = 0; wel = 0;
        polls_left = 0; busy_cfg = busy_n; to = 0; k = 0; pages = 0;
        seed = 8'(addr ^ len);
        @(negedge clk);
        taken = 0;
        // expected sequence
        case (op)
            0: begin
                a = addr; rem = len;
                while (rem > 0 && !to) begin
                    c = (rem < PG - (a % PG)) ? rem : PG - (a % PG);
                    ex_open(); ex_b(8'h06); ex_close();
                    ex_open(); ex_b(8'h02); ex_addr(a);
                    for (int i = 0; i < c; i++) begin ex_b(pat(k, seed)); k++; end
                    ex_close();
                    ex_polls(busy_n, pmax, to);
                    pages++;
                    a = (a + c) & 24'hFFFFFF; rem -= c;
                end
            end
            1: begin
                ex_open(); ex_b(8'h06); ex_close();
                ex_open(); ex_b(8'hD8); ex_addr(addr); ex_close();
                ex_polls(busy_n, pmax, to);
            end
            2: begin
                ex_open(); ex_b(8'h06); ex_close();
                ex_open(); ex_b(8'hC7); ex_close();
                ex_polls(busy_n, pmax, to);
            end
            default: begin
                ex_open(); ex_b(8'h06); ex_close();
                ex_open(); ex_b(8'h01); ex_b(8'(sr)); ex_close();
                ex_polls(busy_n, pmax, to);
            end
        endcase
        // issue
        req_op = 2'(op); req_addr = 24'(addr); req_len = LW'(len); req_sr = 8'(sr);
        poll_gap = TW'(pgap); poll_max = TW'(pmax);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = poke;
        if (poke) req_op = 2'd2;
        chk(busy == 1'b1, "R8", "busy one cycle after accept", int'(busy), 1);
        chk(err == 1'b0, "R7", "error cleared on accept", int'(err), 0);
        cyc = 0; bz_ok = 1;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc >= 30) req_valid = 1'b0;
            if (!done && !busy) bz_ok = 0;
        end
        req_valid = 1'b0;
        chk(done == 1'b1, "R8", "done reached", int'(done), 1);
        chk(bz_ok, "R8", "busy held until done", int'(bz_ok), 1);
        chk(busy == 1'b0, "R8", "busy low with done", int'(busy), 0);
        chk(err == to, "R7", "timeout flag", int'(err), int'(to));
        rq = (op == 0) ? "R3" : "R1";
        chk(mfc == efc, rq, "frame count", mfc, efc);
        if (op == 0) begin
            int npp = 0;
            for (int f = 0; f < mfc && f < 256; f++) if (mfl[f] > 0 && mb[mfs[f]] == 8'h02) npp++;
            chk(npp == pages, "R3", "program frames per page", npp, pages);
            chk(taken == k, "R2", "data bytes taken", taken, k);
        end
        if (poke) chk(mfc == efc, "R8", "request while busy ignored", mfc, efc);
        chk(seq_viol == 0, "R1", "modify frame without write enable", seq_viol, 0);
        frames_ok = 1;
        for (int f = 0; f < efc && f < mfc; f++) begin
            bit ok;
            logic [7:0] fb;
            ok = (mfl[f] == efl[f]);
            for (int i = 0; ok && i < efl[f]; i++) if (mb[mfs[f] + i] != eb[efs[f] + i]) ok = 0;
            fb = eb[efs[f]];
            if (fb == 8'h06)      rq = "R1";
            else if (fb == 8'h02) rq = "R2";
            else if (fb == 8'h05) rq = "R5";
            else                  rq = "R4";
            if (!ok) begin
                frames_ok = 0;
                chk(0, rq, $sformatf("frame %0d length/first byte", f),
                    (mfl[f] << 8) | mb[mfs[f]], (efl[f] << 8) | fb);
            end
        end
        chk(frames_ok, (op == 0) ? "R2" : "R4", "all frame bytes", int'(frames_ok), 1);
        min_gap = 1 << 30; min_pgap = 1 << 30;
        for (int f = 1; f < mfc && f < 256; f++) begin
            if (mgap[f] < min_gap) min_gap = mgap[f];
            if (mfl[f] > 0 && mb[mfs[f]] == 8'h05 && mgap[f] < min_pgap) min_pgap = mgap[f];
        end
        chk(min_gap >= GAP, "R9", "cs high between frames", min_gap, GAP);
        chk(min_pgap >= GAP + pgap, "R6", "cs high before status read", min_pgap, GAP + pgap);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int offs [5];
        int lens [6];
        int n;
        offs = '{0, 1, 7, 14, 15};
        lens = '{1, 2, 15, 16, 17, 33};
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_len = '0;
        req_sr = '0; poll_gap = '0; poll_max = TW'(8);
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R11", "spi lines in reset",
            {spi_cs_n, spi_sclk}, 2);
        chk({busy, done, err, wdata_take} == 4'b0, "R11", "status outputs in reset",
            {busy, done, err, wdata_take}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1;
        chk(busy == 1'b0 && spi_cs_n == 1'b1, "R11", "idle after reset",
            {busy, spi_cs_n}, 1);
        // R3 / R2 sweep over page offsets and lengths
        n = 0;
        foreach (offs[i]) foreach (lens[j]) begin
            run_op(0, 24'h12_3400 + 32 * i + offs[i], lens[j], 0, n % 3, 8, (n % 3) * 2, 0);
            n++;
        end
        // program across the top of the address space
        run_op(0, 24'hFF_FFF9, 12, 0, 1, 8, 1, 0);
        // R4 erases and status writes
        run_op(1, 24'hAB_CDEF, 0, 0, 4, 8, 3, 1);
        run_op(1, 24'h00_0010, 0, 0, 0, 8, 0, 0);
        run_op(2, 24'h55_5555, 0, 0, 2, 8, 1, 0);
        run_op(3, 0, 0, 8'h9C, 1, 8, 0, 0);
        run_op(3, 0, 0, 8'hFF, 0, 8, 2, 0);
        run_op(3, 0, 0, 8'h00, 3, 8, 1, 0);
        // R7 timeout, remaining pages dropped, flag held
        run_op(0, 24'h00_2007, 33, 0, 100, 3, 2, 0);
        repeat (5) @(negedge clk);
        chk(err == 1'b1, "R7", "timeout flag held while idle", int'(err), 1);
        run_op(2, 0, 0, 0, 100, 0, 0, 0);
        run_op(1, 24'h01_0000, 0, 0, 1, 4, 0, 0);
        // R10 zero-length program
        mfc = 0;
        req_op = 2'd0; req_len = '0; req_addr = 24'h00_0005; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R10", "zero-length accepted",
            {busy, done}, 2);
        @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R10", "zero-length done after two cycles",
            {done, busy}, 2);
        repeat (20) @(negedge clk);
        chk(mfc == 0, "R10", "zero-length frames", mfc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule